// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a multicycle processor datapath, built as a small microprogrammed engine instead of a hand-drawn state machine. A microprogram counter selects one word from an internal constant microcode store. Each word holds a label, an ALU function, a choice for each of the two ALU operands, a register-file action, a memory action, a PC-update action and a next-address rule. The sequencer decodes these fields into the control lines that steer the datapath, and it shows the current microaddress on a port.

The next microaddress is chosen in one of four ways: step to the following word, jump back to the fetch word, look up the opcode in the first dispatch table (after decode), or look up the opcode in the second dispatch table (after the address step of a memory instruction). Steps that touch memory hold the counter until the memory signals it is ready, so a slow memory simply stretches the step. An opcode that the first table does not know raises an illegal-instruction flag and sends the engine back to fetch.

Top module: `usc_sequencer`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, upc is 0.
- R2: At microaddress 0 (fetch) the outputs are alu_op=00 (add), alu_src1=0 (PC), alu_src2=01 (constant 4), mem_rd=1 with mem_addr_alu=0 (address from PC), and pc_src=00 (ALU result); ir_wr and pc_wr equal mem_ready; the next address is 1.
- R3: At microaddress 1 (decode) the outputs are alu_op=00, alu_src1=0, alu_src2=11 (sign-extended immediate shifted left by 2), reg_rd=1, and no write or memory line is high.
- R4: At microaddress 1 the next address comes from dispatch table 1: opcode 0 (register format) gives 6, opcode 35 (load) and opcode 43 (store) give 2, opcode 4 (branch if equal) gives 8, opcode 2 (jump) gives 9.
- R5: At microaddress 1, any opcode other than 0, 35, 43, 4 and 2 drives illegal_op high in that cycle and the next address is 0; illegal_op is low at every other time.
- R6: At microaddress 2 (address step: alu_op=00, alu_src1=1 for register A, alu_src2=10 for sign-extended immediate) the next address comes from dispatch table 2: opcode 35 gives 3, opcode 43 gives 5, any other gives 0.
- R7: A step whose memory action is not none (addresses 0, 3, 5) keeps upc unchanged on a clock edge where mem_ready is low.
- R8: pc_wr, reg_wr and ir_wr are high only in a cycle where the microprogram counter advances; in a stalled cycle they are low.
- R9: reg_wr is never high at microaddress 0 or 1.
- R10: Later steps drive: 3 mem_rd=1, mem_addr_alu=1, then 4; 4 reg_wr=1, reg_wr_mdr=1, then 0; 5 mem_wr=1, mem_addr_alu=1, then 0; 6 alu_op=10 (function field), alu_src1=1, alu_src2=00 (B), then 7; 7 reg_wr=1, reg_wr_mdr=0, then 0; 8 alu_op=01 (subtract), alu_src1=1, alu_src2=00, pc_wr_cond=1, pc_src=01 (ALU output register), then 0; 9 pc_wr=1, pc_src=10 (jump address), then 0. Unlisted lines are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opcode | input | 6 | Opcode field of the instruction register |
| mem_ready | input | 1 | Memory has completed the current access |
| alu_op | output | 2 | 00 add, 01 subtract, 10 use function field |
| alu_src1 | output | 1 | 0 PC, 1 register A |
| alu_src2 | output | 2 | 00 B, 01 four, 10 sign-extended, 11 sign-extended shifted |
| reg_rd | output | 1 | Read register file into A and B |
| reg_wr | output | 1 | Register file write strobe |
| reg_wr_mdr | output | 1 | Write data from memory data register (else ALU output) |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr_alu | output | 1 | Memory address from ALU output register (else PC) |
| ir_wr | output | 1 | Instruction register load strobe |
| pc_wr | output | 1 | Unconditional PC write strobe |
| pc_wr_cond | output | 1 | PC write if the ALU zero flag is set |
| pc_src | output | 2 | 00 ALU result, 01 ALU output register, 10 jump address |
| illegal_op | output | 1 | Opcode not found in dispatch table 1 |
| upc | output | 4 | Current microaddress |

## Verification
The fetch step is where a memory stall and the PC and instruction-register commits meet in one cycle. The bench holds mem_ready low for several cycles at fetch and at the load and store steps, mixed with random ready patterns, and judges that upc stays put while the commit strobes stay low, then that both strobes rise for exactly the cycle in which ready returns. A second meeting point is decode, where the register read and the illegal-opcode return share a cycle; opcodes outside the table are injected and the flag, the read line and the return to address 0 are judged together.

// File: rtl/usc_pkg.sv
package usc_pkg;

  typedef enum logic [1:0] {
    SQ_NEXT  = 2'b00,
    SQ_FETCH = 2'b01,
    SQ_DSP1  = 2'b10,
    SQ_DSP2  = 2'b11
  } seq_e;

  typedef enum logic [1:0] {
    AF_ADD  = 2'b00,
    AF_SUB  = 2'b01,
    AF_FUNC = 2'b10
  } aluf_e;

  typedef enum logic [1:0] {
    RC_NONE  = 2'b00,
    RC_READ  = 2'b01,
    RC_WRALU = 2'b10,
    RC_WRMDR = 2'b11
  } regc_e;

  typedef enum logic [1:0] {
    MC_NONE  = 2'b00,
    MC_RDPC  = 2'b01,
    MC_RDALU = 2'b10,
    MC_WRALU = 2'b11
  } memc_e;

  typedef enum logic [1:0] {
    PW_NONE = 2'b00,
    PW_ALU  = 2'b01,
    PW_COND = 2'b10,
    PW_JUMP = 2'b11
  } pcw_e;

  typedef struct packed {
    logic [3:0] label;
    aluf_e      alu;
    logic       src1;
    logic [1:0] src2;
    regc_e      regc;
    memc_e      mem;
    pcw_e       pcw;
    seq_e       seq;
  } uword_t;

  localparam logic [5:0] OP_RFMT  = 6'd0;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_JUMP  = 6'd2;

  function automatic uword_t mk(input logic [3:0] lb, input aluf_e a, input logic s1,
                                input logic [1:0] s2, input regc_e r, input memc_e m,
                                input pcw_e p, input seq_e s);
    uword_t w;
    w.label = lb; w.alu = a; w.src1 = s1; w.src2 = s2;
    w.regc = r; w.mem = m; w.pcw = p; w.seq = s;
    return w;
  endfunction

  // Microprogram content, one word per address.
  function automatic uword_t ucode_word(input int unsigned a);
    case (a)
      0: return mk(4'd0, AF_ADD,  1'b0, 2'b01, RC_NONE,  MC_RDPC,  PW_ALU,  SQ_NEXT);
      1: return mk(4'd1, AF_ADD,  1'b0, 2'b11, RC_READ,  MC_NONE,  PW_NONE, SQ_DSP1);
      2: return mk(4'd2, AF_ADD,  1'b1, 2'b10, RC_NONE,  MC_NONE,  PW_NONE, SQ_DSP2);
      3: return mk(4'd3, AF_ADD,  1'b0, 2'b00, RC_NONE,  MC_RDALU, PW_NONE, SQ_NEXT);
      4: return mk(4'd4, AF_ADD,  1'b0, 2'b00, RC_WRMDR, MC_NONE,  PW_NONE, SQ_FETCH);
      5: return mk(4'd5, AF_ADD,  1'b0, 2'b00, RC_NONE,  MC_WRALU, PW_NONE, SQ_FETCH);
      6: return mk(4'd6, AF_FUNC, 1'b1, 2'b00, RC_NONE,  MC_NONE,  PW_NONE, SQ_NEXT);
      7: return mk(4'd7, AF_ADD,  1'b0, 2'b00, RC_WRALU, MC_NONE,  PW_NONE, SQ_FETCH);
      8: return mk(4'd8, AF_SUB,  1'b1, 2'b00, RC_NONE,  MC_NONE,  PW_COND, SQ_FETCH);
      9: return mk(4'd9, AF_ADD,  1'b0, 2'b00, RC_NONE,  MC_NONE,  PW_JUMP, SQ_FETCH);
      default: return mk(4'(a), AF_ADD, 1'b0, 2'b00, RC_NONE, MC_NONE, PW_NONE, SQ_FETCH);
    endcase
  endfunction

endpackage

// File: rtl/usc_store.sv
module usc_store
  import usc_pkg::*;
#(
  parameter int UDEPTH  = 16,
  localparam int UADDR_W = $clog2(UDEPTH)
) (
  input  logic [UADDR_W-1:0] addr,
  output uword_t             word
);
  uword_t rom [UDEPTH];

  for (genvar i = 0; i < UDEPTH; i++) begin : g_word
    assign rom[i] = ucode_word(i);
  end

  assign word = rom[addr];
endmodule

// File: rtl/usc_dispatch.sv
module usc_dispatch
  import usc_pkg::*;
#(
  parameter int OPC_W   = 6,
  parameter int UADDR_W = 4
) (
  input  logic [OPC_W-1:0]   opcode,
  output logic [UADDR_W-1:0] d1_addr,
  output logic               d1_hit,
  output logic [UADDR_W-1:0] d2_addr
);
  always_comb begin
    d1_hit  = 1'b1;
    d1_addr = '0;
    case (opcode)
      OPC_W'(OP_RFMT):  d1_addr = UADDR_W'(6);
      OPC_W'(OP_LOAD),
      OPC_W'(OP_STORE): d1_addr = UADDR_W'(2);
      OPC_W'(OP_BEQ):   d1_addr = UADDR_W'(8);
      OPC_W'(OP_JUMP):  d1_addr = UADDR_W'(9);
      default:          d1_hit  = 1'b0;
    endcase
  end

  always_comb begin
    case (opcode)
      OPC_W'(OP_LOAD):  d2_addr = UADDR_W'(3);
      OPC_W'(OP_STORE): d2_addr = UADDR_W'(5);
      default:          d2_addr = '0;
    endcase
  end
endmodule

// File: rtl/usc_decode.sv
module usc_decode
  import usc_pkg::*;
(
  input  uword_t     word,
  input  logic       mem_ready,
  output logic       advance,
  output logic [1:0] alu_op,
  output logic       alu_src1,
  output logic [1:0] alu_src2,
  output logic       reg_rd,
  output logic       reg_wr,
  output logic       reg_wr_mdr,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       mem_addr_alu,
  output logic       ir_wr,
  output logic       pc_wr,
  output logic       pc_wr_cond,
  output logic [1:0] pc_src
);
  logic mem_busy;
  assign mem_busy     = (word.mem != MC_NONE);
  assign advance      = !mem_busy || mem_ready;

  assign alu_op       = word.alu;
  assign alu_src1     = word.src1;
  assign alu_src2     = word.src2;

  assign reg_rd       = (word.regc == RC_READ);
  assign reg_wr       = (word.regc == RC_WRALU || word.regc == RC_WRMDR) && advance;
  assign reg_wr_mdr   = (word.regc == RC_WRMDR);

  assign mem_rd       = (word.mem == MC_RDPC) || (word.mem == MC_RDALU);
  assign mem_wr       = (word.mem == MC_WRALU);
  assign mem_addr_alu = (word.mem == MC_RDALU) || (word.mem == MC_WRALU);
  assign ir_wr        = (word.mem == MC_RDPC) && advance;

  assign pc_wr        = (word.pcw == PW_ALU || word.pcw == PW_JUMP) && advance;
  assign pc_wr_cond   = (word.pcw == PW_COND);

  always_comb begin
    case (word.pcw)
      PW_COND: pc_src = 2'b01;
      PW_JUMP: pc_src = 2'b10;
      default: pc_src = 2'b00;
    endcase
  end
endmodule

// File: rtl/usc_sequencer.sv
module usc_sequencer
  import usc_pkg::*;
#(
  parameter int UDEPTH  = 16,
  parameter int OPC_W   = 6,
  localparam int UADDR_W = $clog2(UDEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OPC_W-1:0]   opcode,
  input  logic               mem_ready,
  output logic [1:0]         alu_op,
  output logic               alu_src1,
  output logic [1:0]         alu_src2,
  output logic               reg_rd,
  output logic               reg_wr,
  output logic               reg_wr_mdr,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic               mem_addr_alu,
  output logic               ir_wr,
  output logic               pc_wr,
  output logic               pc_wr_cond,
  output logic [1:0]         pc_src,
  output logic               illegal_op,
  output logic [UADDR_W-1:0] upc
);
  uword_t             cur_word;
  logic [UADDR_W-1:0] d1_addr, d2_addr, nxt_upc;
  logic               d1_hit, advance;
  logic [3:0]         cur_label;

  usc_store #(.UDEPTH(UDEPTH)) u_store (.addr(upc), .word(cur_word));

  usc_dispatch #(.OPC_W(OPC_W), .UADDR_W(UADDR_W)) u_disp (
    .opcode(opcode), .d1_addr(d1_addr), .d1_hit(d1_hit), .d2_addr(d2_addr)
  );

  usc_decode u_dec (
    .word(cur_word), .mem_ready(mem_ready), .advance(advance),
    .alu_op(alu_op), .alu_src1(alu_src1), .alu_src2(alu_src2),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wr_mdr(reg_wr_mdr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr_alu(mem_addr_alu),
    .ir_wr(ir_wr), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_src(pc_src)
  );

  assign cur_label  = cur_word.label;
  assign illegal_op = (cur_word.seq == SQ_DSP1) && !d1_hit;

  always_comb begin
    case (cur_word.seq)
      SQ_NEXT:  nxt_upc = upc + UADDR_W'(1);
      SQ_DSP1:  nxt_upc = d1_hit ? d1_addr : '0;
      SQ_DSP2:  nxt_upc = d2_addr;
      default:  nxt_upc = '0;
    endcase
    if (!advance) nxt_upc = upc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) upc <= '0;
    else        upc <= nxt_upc;
  end
endmodule

// File: rtl/usc_sequencer_chk.sv
module usc_sequencer_chk #(
  parameter int UADDR_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mem_ready,
  input logic               mem_rd,
  input logic               mem_wr,
  input logic               reg_wr,
  input logic               ir_wr,
  input logic               pc_wr,
  input logic               illegal_op,
  input logic [3:0]         label,
  input logic [UADDR_W-1:0] upc
);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && !mem_ready) |=> $stable(upc));

  // R8
  commit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr || ir_wr || reg_wr) |=> !$stable(upc) || upc == '0);

  // R9
  early_regwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (upc > UADDR_W'(1)));

  // R5
  illegal_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |=> (upc == '0));

  // R2
  fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == '0 && mem_ready) |=> (upc == UADDR_W'(1)));

  // R10
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr}));

  // R10
  label_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    UADDR_W'(label) == upc);
endmodule

bind usc_sequencer usc_sequencer_chk #(.UADDR_W(UADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_ready(mem_ready), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .reg_wr(reg_wr), .ir_wr(ir_wr), .pc_wr(pc_wr), .illegal_op(illegal_op),
  .label(cur_label), .upc(upc)
);

// File: tb/usc_sequencer_test.sv
module usc_sequencer_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = 6'd0;
  logic       mem_ready = 1'b0;
  logic [1:0] alu_op, alu_src2, pc_src;
  logic       alu_src1, reg_rd, reg_wr, reg_wr_mdr, mem_rd, mem_wr, mem_addr_alu;
  logic       ir_wr, pc_wr, pc_wr_cond, illegal_op;
  logic [3:0] upc;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usc_sequencer uut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .mem_ready(mem_ready),
    .alu_op(alu_op), .alu_src1(alu_src1), .alu_src2(alu_src2),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wr_mdr(reg_wr_mdr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr_alu(mem_addr_alu),
    .ir_wr(ir_wr), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_src(pc_src),
    .illegal_op(illegal_op), .upc(upc)
  );

  // Packed order: alu_op,src1,src2,reg_rd,reg_wr,reg_wr_mdr,mem_rd,mem_wr,mem_addr_alu,ir_wr,pc_wr,pc_wr_cond,pc_src
  function automatic logic [15:0] pack_ctrl(logic [1:0] a, logic s1, logic [1:0] s2, logic rr,
      logic rw, logic rm, logic mr, logic mw, logic ma, logic iw, logic pw, logic pc, logic [1:0] ps);
    return {a, s1, s2, rr, rw, rm, mr, mw, ma, iw, pw, pc, ps};
  endfunction

  function automatic logic [15:0] want_ctrl(logic [3:0] a, logic rdy);
    case (a)
      4'd0: return pack_ctrl(2'b00, 0, 2'b01, 0, 0, 0, 1, 0, 0, rdy, rdy, 0, 2'b00);
      4'd1: return pack_ctrl(2'b00, 0, 2'b11, 1, 0, 0, 0, 0, 0, 0, 0, 0, 2'b00);
      4'd2: return pack_ctrl(2'b00, 1, 2'b10, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b00);
      4'd3: return pack_ctrl(2'b00, 0, 2'b00, 0, 0, 0, 1, 0, 1, 0, 0, 0, 2'b00);
      4'd4: return pack_ctrl(2'b00, 0, 2'b00, 0, 1, 1, 0, 0, 0, 0, 0, 0, 2'b00);
      4'd5: return pack_ctrl(2'b00, 0, 2'b00, 0, 0, 0, 0, 1, 1, 0, 0, 0, 2'b00);
      4'd6: return pack_ctrl(2'b10, 1, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b00);
      4'd7: return pack_ctrl(2'b00, 0, 2'b00, 0, 1, 0, 0, 0, 0, 0, 0, 0, 2'b00);
      4'd8: return pack_ctrl(2'b01, 1, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2'b01);
      4'd9: return pack_ctrl(2'b00, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0, 1, 0, 2'b10);
      default: return '0;
    endcase
  endfunction

  function automatic bit known_op(logic [5:0] op);
    return op == 6'd0 || op == 6'd35 || op == 6'd43 || op == 6'd4 || op == 6'd2;
  endfunction

  function automatic logic [3:0] want_next(logic [3:0] a, logic [5:0] op, logic rdy);
    if ((a == 4'd0 || a == 4'd3 || a == 4'd5) && !rdy) return a;
    case (a)
      4'd0: return 4'd1;
      4'd1: begin
        if (op == 6'd0) return 4'd6;
        if (op == 6'd35 || op == 6'd43) return 4'd2;
        if (op == 6'd4) return 4'd8;
        if (op == 6'd2) return 4'd9;
        return 4'd0;
      end
      4'd2: return (op == 6'd35) ? 4'd3 : (op == 6'd43) ? 4'd5 : 4'd0;
      4'd3: return 4'd4;
      4'd6: return 4'd7;
      default: return 4'd0;
    endcase
  endfunction

  function automatic string ctrl_tag(logic [3:0] a, logic rdy);
    if (a == 4'd0) return rdy ? "R2" : "R8";
    if (a == 4'd1) return "R3";
    if (a == 4'd2) return "R6";
    return "R10";
  endfunction

  task automatic check_vec(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  logic [3:0] m_upc = 4'd0;

  // One cycle: drive at negedge, compare after settling, then clock.
  task automatic step(logic [5:0] op, logic rdy);
    logic [3:0] nx;
    string nt;
    @(negedge clk);
    opcode = op;
    mem_ready = rdy;
    #1;
    check_vec(ctrl_tag(m_upc, rdy),
              pack_ctrl(alu_op, alu_src1, alu_src2, reg_rd, reg_wr, reg_wr_mdr, mem_rd,
                        mem_wr, mem_addr_alu, ir_wr, pc_wr, pc_wr_cond, pc_src),
              want_ctrl(m_upc, rdy));
    check_vec("R5", {15'd0, illegal_op}, {15'd0, (m_upc == 4'd1) && !known_op(op)});
    nx = want_next(m_upc, op, rdy);
    if (nx == m_upc && m_upc != 4'd1) nt = "R7";
    else if (m_upc == 4'd1) nt = known_op(op) ? "R4" : "R5";
    else if (m_upc == 4'd2) nt = "R6";
    else nt = "R10";
    @(posedge clk);
    #1;
    check_vec(nt, {12'd0, upc}, {12'd0, nx});
    m_upc = nx;
  endtask

  function automatic logic [5:0] pick_op();
    case ($urandom % 7)
      0: return 6'd0;
      1: return 6'd35;
      2: return 6'd43;
      3: return 6'd4;
      4: return 6'd2;
      default: return 6'($urandom);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [5:0] op;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check_vec("R1", {12'd0, upc}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_vec("R1", {12'd0, upc}, 16'd0);

    // Directed: long stall at fetch, then a load with stalls at its memory step
    repeat (4) step(6'd35, 1'b0);
    step(6'd35, 1'b1);
    step(6'd35, 1'b1);
    step(6'd35, 1'b1);
    repeat (3) step(6'd35, 1'b0);
    step(6'd35, 1'b1);
    step(6'd35, 1'b1);
    // Store with stall on write
    step(6'd43, 1'b1); step(6'd43, 1'b1); step(6'd43, 1'b1);
    step(6'd43, 1'b0); step(6'd43, 1'b1);
    // Illegal opcodes 63 and 5
    step(6'd63, 1'b1); step(6'd63, 1'b1);
    step(6'd5, 1'b1);  step(6'd5, 1'b1);
    // Register format, branch, jump
    foreach (op[i]) begin end
    for (int k = 0; k < 3; k++) begin
      op = (k == 0) ? 6'd0 : (k == 1) ? 6'd4 : 6'd2;
      while (1) begin
        step(op, 1'b1);
        if (m_upc == 4'd0) break;
      end
    end

    // Random mix; opcode changes only at fetch
    op = pick_op();
    for (int n = 0; n < 2000; n++) begin
      if (m_upc == 4'd0) op = pick_op();
      step(op, ($urandom % 4) != 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule